// File: doc/BRIEF.md
# SMBus Indexed Block Configuration Register Target

This block is a target on a two-wire SMBus segment. It answers only to its own fixed 7-bit address and holds a bank of eight byte-wide registers. Some registers configure the rest of the chip, some report identity, and one reflects a latched mode. The host writes with an indexed block write: it sends the address with the write bit, a starting index, a byte count and then that many data bytes. It reads with an indexed block read: it sends the address with the write bit and the index, then a repeated START and the address with the read bit. The target replies with a byte count and then data taken from successive indexes.

The block samples SCL and SDA with a fast system clock. Each line passes through a two-flop synchronizer and a glitch filter before any edge is detected. The block pulls SDA low through an open-drain enable and never drives SCL. The writable fields appear as parallel outputs. A two-bit mode status input is merged into the read path.

Top module: `smb_cfg_target`

## Requirements
- R1: The target acknowledges only the address byte 0xDA (address 0x6D, write) or 0xDB (address 0x6D, read). Any other address byte is not acknowledged, and the bus is then ignored until the next START.
- R2: In a write, the byte after the address sets the index pointer (low 3 bits) and the next byte sets the write count. Each later data byte, while the count is nonzero, is acknowledged, stored at the pointer, and then the pointer advances.
- R3: A data byte that arrives after the write count is used up is answered with NACK and is not stored.
- R4: In a read, the first byte returned is the read-count field (register 7 bits [4:0], upper bits zero). It is followed by the register contents from the pointer onward, one register per byte.
- R5: Once as many data bytes as the read count have been sent, every further byte the host acknowledges reads 0xFF. A host NACK ends the transfer.
- R6: Reset values at the outputs are: output enables 2'b11 (register 0 [1:0]), amplitude 2'b01 (register 1 [1:0]), mode software enable 0 (register 1 [5]), software mode 2'b00 (register 1 [4:3]), slew 2'b11 (register 2 [1:0]), frequency software enable 0 (register 3 [5]), frequency code 2'b00 (register 3 [4:3]), feedback slew 1 (register 3 [0]), read count 8 (register 7 [4:0]).
- R7: Register 4 reads 0xFF, register 5 reads 0x01 and register 6 reads 0x42. Reserved bits keep their fixed values: register 0 bits [7:2] read 1, register 1 bit 2 reads 0, register 3 bits 7, 6, 2 and 1 read 1, and register 7 bits [7:5] read 0. Writes to these bits are acknowledged and discarded.
- R8: Register 1 bits [7:6] read as the current value of the mode status input.
- R9: The pointer is 3 bits wide and wraps from register 7 to register 0 in both reads and writes.
- R10: A STOP or START seen in the middle of a transfer abandons it and releases SDA, and a partly received byte is not stored. After a START a new address phase begins.
- R11: The open-drain enable changes only while the filtered SCL is low. A pulse on SCL or SDA shorter than the filter length is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| mode_lat_i | input | 2 | Latched mode status, read back in register 1 [7:6] |
| out_en_o | output | 2 | Output enable controls, register 0 [1:0] |
| amp_sel_o | output | 2 | Amplitude select, register 1 [1:0] |
| mode_sw_en_o | output | 1 | Software mode control enable, register 1 [5] |
| mode_sw_o | output | 2 | Software mode code, register 1 [4:3] |
| slew_fast_o | output | 2 | Per-output slew select, register 2 [1:0] |
| freq_sw_en_o | output | 1 | Software frequency select enable, register 3 [5] |
| freq_sel_o | output | 2 | Frequency select code, register 3 [4:3] |
| fb_slew_fast_o | output | 1 | Feedback slew select, register 3 [0] |
| rd_cnt_o | output | 5 | Block read count, register 7 [4:0] |

## Verification
A wrong pointer or a wrong byte-kind state shows up within one byte time (nine SCL periods). The symptom is a misplaced acknowledge bit, a parallel output that changes in the wrong field, or a read byte that comes from the wrong register. The read path shows it best, because the count byte and each data byte come out on SDA in a known order. A wrap error at index 7 or a count that does not expire turns the next byte into the wrong value. A state machine that fails to return to idle after STOP or a mid-byte START is seen at the next transfer: its address or first data byte is then acknowledged or stored wrongly. A filter fault adds a phantom SCL edge, which shifts every later bit of the byte.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = 3;
  localparam int NREG     = 1 << IDX_W;
  localparam int CNT_W    = 5;
  localparam int MODE_REG = 1;
  localparam int CNT_REG  = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK
  } link_st_e;

  typedef enum logic [1:0] {
    K_ADDR, K_IDX, K_CNT, K_DATA
  } byte_kind_e;

  // reset / fixed value of each register
  function automatic logic [BYTE_W-1:0] reg_reset(input int i);
    case (i)
      0: return 8'hFF;
      1: return 8'h01;
      2: return 8'hFF;
      3: return 8'hC7;
      4: return 8'hFF;
      5: return 8'h01;
      6: return 8'h42;
      7: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  // bits that a host write may change
  function automatic logic [BYTE_W-1:0] reg_wmask(input int i);
    case (i)
      0: return 8'h03;
      1: return 8'h3B;
      2: return 8'h03;
      3: return 8'h39;
      7: return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_deglitch.sv
module smb_deglitch #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt, cnt_n;
  logic          q, q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= din;
      s2 <= s1;
    end
  end

  always_comb begin
    cnt_n = cnt;
    q_n   = q;
    if (s2 == q) begin
      cnt_n = '0;
    end else if (cnt == CW'(FILT_LEN - 1)) begin
      q_n   = s2;
      cnt_n = '0;
    end else begin
      cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b1;
    end else begin
      cnt <= cnt_n;
      q   <= q_n;
    end
  end

  assign dout = q;
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign ev_start = scl_d &  scl_f &  sda_d & ~sda_f;
  assign ev_stop  = scl_d &  scl_f & ~sda_d &  sda_f;
  assign ev_rise  = ~scl_d &  scl_f;
  assign ev_fall  =  scl_d & ~scl_f;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic [1:0]        mode_lat_i,
  output logic [1:0]        out_en_o,
  output logic [1:0]        amp_sel_o,
  output logic              mode_sw_en_o,
  output logic [1:0]        mode_sw_o,
  output logic [1:0]        slew_fast_o,
  output logic              freq_sw_en_o,
  output logic [1:0]        freq_sel_o,
  output logic              fb_slew_fast_o,
  output logic [CNT_W-1:0]  rd_cnt_o
);
  logic [BYTE_W-1:0] qv [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [BYTE_W-1:0] RV = reg_reset(i);
    localparam logic [BYTE_W-1:0] WM = reg_wmask(i);
    logic [BYTE_W-1:0] r;
    logic              hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   r <= RV;
      else if (hit) r <= (r & ~WM) | (wr_data_i & WM);
    end
    assign qv[i] = r;
  end

  always_comb begin
    rd_data_o = qv[rd_idx_i];
    if (rd_idx_i == IDX_W'(MODE_REG)) rd_data_o[7:6] = mode_lat_i;
  end

  assign out_en_o       = qv[0][1:0];
  assign amp_sel_o      = qv[1][1:0];
  assign mode_sw_en_o   = qv[1][5];
  assign mode_sw_o      = qv[1][4:3];
  assign slew_fast_o    = qv[2][1:0];
  assign freq_sw_en_o   = qv[3][5];
  assign freq_sel_o     = qv[3][4:3];
  assign fb_slew_fast_o = qv[3][0];
  assign rd_cnt_o       = qv[CNT_REG][CNT_W-1:0];
endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_f,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic [CNT_W-1:0]  rd_cnt_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  ptr_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              sda_oe_o
);
  link_st_e          st, st_n;
  byte_kind_e        kind, kind_n;
  logic [3:0]        bitc, bitc_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              ack_q, ack_n;
  logic              dir, dir_n;
  logic              hack, hack_n;
  logic [IDX_W-1:0]  ptr, ptr_n;
  logic [BYTE_W-1:0] wleft, wleft_n;
  logic [CNT_W-1:0]  tleft, tleft_n;

  always_comb begin
    st_n    = st;
    kind_n  = kind;
    bitc_n  = bitc;
    sh_n    = sh;
    ack_n   = ack_q;
    dir_n   = dir;
    hack_n  = hack;
    ptr_n   = ptr;
    wleft_n = wleft;
    tleft_n = tleft;
    wr_en_o = 1'b0;
    if (ev_start) begin
      st_n   = S_RX;
      kind_n = K_ADDR;
      bitc_n = 4'd0;
      ack_n  = 1'b0;
    end else if (ev_stop) begin
      st_n  = S_IDLE;
      ack_n = 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (ev_rise && bitc != 4'd8) begin
            sh_n   = {sh[BYTE_W-2:0], sda_f};
            bitc_n = bitc + 4'd1;
          end else if (ev_fall && bitc == 4'd8) begin
            st_n  = S_RXACK;
            ack_n = 1'b1;
            case (kind)
              K_ADDR: begin
                if (sh[7:1] != DEV_ADDR) begin
                  st_n  = S_IDLE;
                  ack_n = 1'b0;
                end else begin
                  dir_n = sh[0];
                end
              end
              K_IDX: ptr_n = sh[IDX_W-1:0];
              K_CNT: wleft_n = sh;
              default: begin
                if (wleft != '0) begin
                  wr_en_o = 1'b1;
                  ptr_n   = ptr + 1'b1;
                  wleft_n = wleft - 1'b1;
                end else begin
                  ack_n = 1'b0;
                end
              end
            endcase
          end
        end
        S_RXACK: begin
          if (ev_fall) begin
            ack_n  = 1'b0;
            bitc_n = 4'd0;
            if (!ack_q) begin
              st_n = S_IDLE;
            end else if (kind == K_ADDR && dir) begin
              st_n    = S_TX;
              sh_n    = {{(BYTE_W-CNT_W){1'b0}}, rd_cnt_i};
              tleft_n = rd_cnt_i;
            end else begin
              st_n = S_RX;
              case (kind)
                K_ADDR:  kind_n = K_IDX;
                K_IDX:   kind_n = K_CNT;
                default: kind_n = K_DATA;
              endcase
            end
          end
        end
        S_TX: begin
          if (ev_fall) begin
            if (bitc == 4'd7) begin
              st_n   = S_TXACK;
              hack_n = 1'b0;
            end else begin
              sh_n   = {sh[BYTE_W-2:0], 1'b0};
              bitc_n = bitc + 4'd1;
            end
          end
        end
        S_TXACK: begin
          if (ev_rise) begin
            hack_n = ~sda_f;
          end else if (ev_fall) begin
            if (!hack) begin
              st_n = S_IDLE;
            end else begin
              st_n   = S_TX;
              bitc_n = 4'd0;
              if (tleft != '0) begin
                sh_n    = rd_data_i;
                ptr_n   = ptr + 1'b1;
                tleft_n = tleft - 1'b1;
              end else begin
                sh_n = '1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      kind  <= K_ADDR;
      bitc  <= '0;
      sh    <= '0;
      ack_q <= 1'b0;
      dir   <= 1'b0;
      hack  <= 1'b0;
      ptr   <= '0;
      wleft <= '0;
      tleft <= '0;
    end else begin
      st    <= st_n;
      kind  <= kind_n;
      bitc  <= bitc_n;
      sh    <= sh_n;
      ack_q <= ack_n;
      dir   <= dir_n;
      hack  <= hack_n;
      ptr   <= ptr_n;
      wleft <= wleft_n;
      tleft <= tleft_n;
    end
  end

  assign ptr_o    = ptr;
  assign byte_o   = sh;
  assign sda_oe_o = (st == S_RXACK && ack_q) || (st == S_TX && !sh[BYTE_W-1]);
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6D,
  parameter int         FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [1:0]       mode_lat_i,
  output logic [1:0]       out_en_o,
  output logic [1:0]       amp_sel_o,
  output logic             mode_sw_en_o,
  output logic [1:0]       mode_sw_o,
  output logic [1:0]       slew_fast_o,
  output logic             freq_sw_en_o,
  output logic [1:0]       freq_sel_o,
  output logic             fb_slew_fast_o,
  output logic [CNT_W-1:0] rd_cnt_o
);
  logic rs1, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1     <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rs1     <= 1'b1;
      rst_n_s <= rs1;
    end
  end

  logic scl_f, sda_f;
  logic ev_start, ev_stop, ev_rise, ev_fall;
  logic wr_en;
  logic [IDX_W-1:0]  ptr;
  logic [BYTE_W-1:0] wbyte, rd_data;

  smb_deglitch #(.FILT_LEN(FILT_LEN)) u_scl_flt (
    .clk(clk), .rst_n(rst_n_s), .din(scl_i), .dout(scl_f));
  smb_deglitch #(.FILT_LEN(FILT_LEN)) u_sda_flt (
    .clk(clk), .rst_n(rst_n_s), .din(sda_i), .dout(sda_f));

  smb_bus_events u_ev (
    .clk(clk), .rst_n(rst_n_s), .scl_f(scl_f), .sda_f(sda_f),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall));

  smb_link_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .sda_f(sda_f),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .rd_data_i(rd_data), .rd_cnt_i(rd_cnt_o),
    .wr_en_o(wr_en), .ptr_o(ptr), .byte_o(wbyte), .sda_oe_o(sda_oe_o));

  smb_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en_i(wr_en), .wr_idx_i(ptr), .wr_data_i(wbyte),
    .rd_idx_i(ptr), .rd_data_o(rd_data), .mode_lat_i(mode_lat_i),
    .out_en_o(out_en_o), .amp_sel_o(amp_sel_o), .mode_sw_en_o(mode_sw_en_o),
    .mode_sw_o(mode_sw_o), .slew_fast_o(slew_fast_o), .freq_sw_en_o(freq_sw_en_o),
    .freq_sel_o(freq_sel_o), .fb_slew_fast_o(fb_slew_fast_o), .rd_cnt_o(rd_cnt_o));
endmodule

// File: rtl/smb_cfg_chk.sv
module smb_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_f,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       wr_en,
  input logic [1:0] out_en
);
  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe);

  // R2
  out_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(out_en));
endmodule

bind smb_cfg_target smb_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .sda_oe(sda_oe_o), .scl_f(scl_f),
  .ev_start(ev_start), .ev_stop(ev_stop), .wr_en(wr_en), .out_en(out_en_o));

// File: tb/sim_smb_cfg_target.sv
`timescale 1ns/1ps
module sim_smb_cfg_target;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1;
  logic host_sda = 1'b1;
  logic [1:0] mode_lat = 2'b10;
  logic sda_oe;
  logic sda_line;
  logic [1:0] out_en, amp_sel, mode_sw, slew, fsel;
  logic mode_sw_en, freq_sw_en, fb_slew;
  logic [4:0] rd_cnt;

  always #2.5 clk = ~clk;
  assign sda_line = host_sda & ~sda_oe;

  smb_cfg_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .mode_lat_i(mode_lat), .out_en_o(out_en), .amp_sel_o(amp_sel),
    .mode_sw_en_o(mode_sw_en), .mode_sw_o(mode_sw), .slew_fast_o(slew),
    .freq_sw_en_o(freq_sw_en), .freq_sel_o(fsel), .fb_slew_fast_o(fb_slew),
    .rd_cnt_o(rd_cnt));

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int    exp_q[$];
  string tag_q[$];
  int    obs_q[$];

  task automatic chk(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      wait (obs_q.size() > 0);
      chk(tag_q.pop_front(), obs_q.pop_front(), exp_q.pop_front());
    end
  end

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; qw(); host_scl = 1'b1; qw(); host_sda = 1'b0; qw(); host_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; qw(); host_scl = 1'b1; qw(); host_sda = 1'b1; qw(); qw();
  endtask

  task automatic put_bit(input logic b, input bit glitch);
    host_sda = b;
    if (glitch) begin
      repeat (Q/2) @(negedge clk);
      host_scl = 1'b1; @(negedge clk); host_scl = 1'b0;
      repeat (Q/2 - 1) @(negedge clk);
    end else qw();
    host_scl = 1'b1; qw(); qw(); host_scl = 1'b0; qw();
  endtask

  task automatic get_bit(output logic b);
    host_sda = 1'b1; qw(); host_scl = 1'b1; qw(); b = sda_line; qw(); host_scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] v, input logic exp_ack_bit,
                           input string tag, input bit glitch = 1'b0);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i], glitch && (i == 3));
    get_bit(a);
    exp_q.push_back(int'(exp_ack_bit)); tag_q.push_back(tag);
    obs_q.push_back(int'(a));
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit host_ack, input string tag);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    exp_q.push_back(int'(exp)); tag_q.push_back(tag);
    obs_q.push_back(int'(v));
    put_bit(host_ack ? 1'b0 : 1'b1, 1'b0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R6 reset state
    chk("R6 out_en", out_en, 2'b11);
    chk("R6 amp", amp_sel, 2'b01);
    chk("R6 mode_sw_en", mode_sw_en, 0);
    chk("R6 mode_sw", mode_sw, 0);
    chk("R6 slew", slew, 2'b11);
    chk("R6 freq_sw_en", freq_sw_en, 0);
    chk("R6 fsel", fsel, 0);
    chk("R6 fb_slew", fb_slew, 1);
    chk("R6 rd_cnt", rd_cnt, 8);
    chk("R6 sda_oe", sda_oe, 0);

    // R1 foreign address ignored
    bus_start();
    send_byte(8'h50, 1'b1, "R1 foreign addr nack");
    send_byte(8'h00, 1'b1, "R1 ignored byte");
    bus_stop();
    chk("R1 out_en untouched", out_en, 2'b11);

    // R2 block write of registers 0..3
    bus_start();
    send_byte(8'hDA, 1'b0, "R1 own addr ack");
    send_byte(8'h00, 1'b0, "R2 index ack");
    send_byte(8'h04, 1'b0, "R2 count ack");
    send_byte(8'h00, 1'b0, "R2 data0 ack");
    send_byte(8'hFF, 1'b0, "R2 data1 ack");
    send_byte(8'h01, 1'b0, "R2 data2 ack");
    send_byte(8'hFF, 1'b0, "R2 data3 ack");
    bus_stop();
    chk("R2 out_en", out_en, 0);
    chk("R2 mode_sw_en", mode_sw_en, 1);
    chk("R2 mode_sw", mode_sw, 3);
    chk("R2 amp", amp_sel, 3);
    chk("R2 slew", slew, 1);
    chk("R2 freq_sw_en", freq_sw_en, 1);
    chk("R2 fsel", fsel, 3);
    chk("R2 fb_slew", fb_slew, 1);

    // read count = 3
    bus_start();
    send_byte(8'hDA, 1'b0, "R4 addr");
    send_byte(8'h07, 1'b0, "R4 index");
    send_byte(8'h01, 1'b0, "R4 count");
    send_byte(8'h03, 1'b0, "R4 data");
    bus_stop();
    chk("R4 rd_cnt", rd_cnt, 3);

    // R3 byte past the count is refused
    bus_start();
    send_byte(8'hDA, 1'b0, "R3 addr");
    send_byte(8'h02, 1'b0, "R3 index");
    send_byte(8'h01, 1'b0, "R3 count");
    send_byte(8'h02, 1'b0, "R3 data");
    send_byte(8'h03, 1'b1, "R3 extra nack");
    bus_stop();
    chk("R3 slew", slew, 2);
    chk("R3 fsel kept", fsel, 3);
    chk("R3 freq_sw_en kept", freq_sw_en, 1);

    // R7 writes to fixed registers
    bus_start();
    send_byte(8'hDA, 1'b0, "R7 addr");
    send_byte(8'h05, 1'b0, "R7 index");
    send_byte(8'h02, 1'b0, "R7 count");
    send_byte(8'h00, 1'b0, "R7 data5 ack");
    send_byte(8'h00, 1'b0, "R7 data6 ack");
    bus_stop();

    // R4/R7 read from index 4
    bus_start();
    send_byte(8'hDA, 1'b0, "R4 addr w");
    send_byte(8'h04, 1'b0, "R4 index");
    bus_start();
    send_byte(8'hDB, 1'b0, "R4 addr r");
    recv_byte(8'h03, 1'b1, "R4 count byte");
    recv_byte(8'hFF, 1'b1, "R7 reg4");
    recv_byte(8'h01, 1'b1, "R7 reg5");
    recv_byte(8'h42, 1'b0, "R7 reg6");
    bus_stop();

    // R9 wrap, R8 readback, R7 reserved bits
    bus_start();
    send_byte(8'hDA, 1'b0, "R9 addr w");
    send_byte(8'h07, 1'b0, "R9 index");
    bus_start();
    send_byte(8'hDB, 1'b0, "R9 addr r");
    recv_byte(8'h03, 1'b1, "R9 count byte");
    recv_byte(8'h03, 1'b1, "R9 reg7");
    recv_byte(8'hFC, 1'b1, "R9 reg0 wrapped");
    recv_byte(8'hBB, 1'b0, "R8 reg1 readback");
    bus_stop();

    // R5 over-read
    bus_start();
    send_byte(8'hDA, 1'b0, "R5 addr w");
    send_byte(8'h06, 1'b0, "R5 index");
    bus_start();
    send_byte(8'hDB, 1'b0, "R5 addr r");
    recv_byte(8'h03, 1'b1, "R5 count byte");
    recv_byte(8'h42, 1'b1, "R5 reg6");
    recv_byte(8'h03, 1'b1, "R5 reg7");
    recv_byte(8'hFC, 1'b1, "R5 reg0");
    recv_byte(8'hFF, 1'b0, "R5 past count");
    bus_stop();

    // R10 stop in the middle of a byte
    bus_start();
    send_byte(8'hDA, 1'b0, "R10 addr");
    send_byte(8'h00, 1'b0, "R10 index");
    send_byte(8'h01, 1'b0, "R10 count");
    for (int i = 0; i < 4; i++) put_bit(1'b0, 1'b0);
    bus_stop();
    chk("R10 partial not stored", out_en, 0);
    chk("R10 sda released", sda_oe, 0);

    // R10 start in mid transfer restarts
    bus_start();
    send_byte(8'hDA, 1'b0, "R10 addr a");
    send_byte(8'h00, 1'b0, "R10 index a");
    send_byte(8'h02, 1'b0, "R10 count a");
    send_byte(8'h01, 1'b0, "R10 data a");
    bus_start();
    send_byte(8'hDA, 1'b0, "R10 addr b");
    send_byte(8'h02, 1'b0, "R10 index b");
    send_byte(8'h01, 1'b0, "R10 count b");
    send_byte(8'h00, 1'b0, "R10 data b");
    bus_stop();
    chk("R10 out_en", out_en, 1);
    chk("R10 slew", slew, 0);

    // R11 short SCL pulse ignored
    bus_start();
    send_byte(8'hDA, 1'b0, "R11 addr");
    send_byte(8'h00, 1'b0, "R11 index");
    send_byte(8'h01, 1'b0, "R11 count");
    send_byte(8'h02, 1'b0, "R11 data glitched", 1'b1);
    bus_stop();
    chk("R11 out_en", out_en, 2);

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule